// File: doc/BRIEF.md
# Galois pseudo-random generator

This block is a pseudo-random sequence source built as a linear feedback shift register with one-to-many feedback. On every enabled clock edge the top stage of the register is fed straight into stage 0 and is also combined into each tapped stage. Every other stage copies its lower neighbour. The register length is fixed at elaboration to any value from 3 to 16 bits. A built-in table of primitive feedback polynomials picks the taps, so each length runs through its maximal sequence.

Each advance produces one value on two outputs: the whole register as a parallel word, and its top stage as a serial bit. Both come from the same register, so they always agree. A synchronous reset loads a fixed non-zero seed. A load strobe copies a caller-supplied seed into the register, and an advance enable steps the sequence. The outputs carry no valid/ready handshake. A consumer that wants a new value raises `advance`. Holding `advance` low stalls the sequence and acts as the back-pressure. When reset and load arrive together, reset wins.

Top module: `galois_prng`

## Requirements
- R1: On an edge with `rst` high, the register becomes the reset seed: bit 0 set, all other bits clear. This happens whatever `load`, `seed_in` and `advance` hold, and for both feedback types.
- R2: On an edge with `rst` low and `load` high, the register takes `seed_in` exactly, even if `advance` is high. Stepping starts on the next edge with `advance` high.
- R3: On an edge with `rst`, `load` and `advance` all low, the register keeps its value.
- R4: On an edge with only `advance` high, stage 0 takes the old top stage (bit WIDTH-1). Each stage i ≥ 1 takes old stage i-1. Where tap-mask bit i is set, that value is first combined with the old top stage by XOR (`XNOR_FB`=0) or XNOR (`XNOR_FB`=1). Stages without a tap shift plainly.
- R5: The tap masks, with polynomial terms below x^WIDTH as bits, are 3:0x003, 4:0x003, 5:0x005, 6:0x003, 7:0x003, 8:0x01D, 9:0x011, 10:0x009, 11:0x005, 12:0x053, 13:0x01B, 14:0x443, 15:0x003 and 16:0x100B.
- R6: For every length from 3 to 16 and both feedback types, the sequence starting from the reset seed returns to it after exactly 2^WIDTH − 1 advances. It never visits the lock-up word on the way.
- R7: The lock-up word is all zeros for XOR feedback and all ones for XNOR feedback. Once the register holds it, advancing leaves it unchanged.
- R8: `serial_out` always equals bit WIDTH-1 of `state_out`, and both change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset to the non-zero seed, highest priority |
| load | input | 1 | Copy `seed_in` into the register on this edge |
| seed_in | input | WIDTH | Seed word for `load` |
| advance | input | 1 | Step the sequence on this edge |
| serial_out | output | 1 | Top stage of the register |
| state_out | output | WIDTH | Whole register word |

## Verification
All three actions (reset, load and step) take effect on the rising edge that samples them. The new word appears on `state_out` and `serial_out` on that edge, with no further register stage. The bench drives inputs on falling edges and pushes the word it expects for the next rising edge into a queue. A monitor pops that entry 1 ns after the rising edge and compares it with both outputs. The long sweeps over every length follow the same one-edge rule: each DUT is compared against a step model at every falling edge after an advancing rising edge.

// File: rtl/prng_pkg.sv
package prng_pkg;

  localparam int MAX_WIDTH = 16;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_RESET = 2'd3
  } prng_act_e;

  // Terms of a primitive polynomial below x^w, one bit per power of x.
  function automatic logic [MAX_WIDTH-1:0] tap_mask(input int w);
    logic [MAX_WIDTH-1:0] m;
    case (w)
      3:       m = 16'h0003;
      4:       m = 16'h0003;
      5:       m = 16'h0005;
      6:       m = 16'h0003;
      7:       m = 16'h0003;
      8:       m = 16'h001D;
      9:       m = 16'h0011;
      10:      m = 16'h0009;
      11:      m = 16'h0005;
      12:      m = 16'h0053;
      13:      m = 16'h001B;
      14:      m = 16'h0443;
      15:      m = 16'h0003;
      16:      m = 16'h100B;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prng_next_state.sv
module prng_next_state #(
  parameter int WIDTH   = 8,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [prng_pkg::MAX_WIDTH-1:0] TAPS = prng_pkg::tap_mask(WIDTH);

  logic fb;
  assign fb     = cur[WIDTH-1];
  assign nxt[0] = fb;

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    if (TAPS[i]) begin : g_tap
      if (XNOR_FB) begin : g_xnor
        assign nxt[i] = ~(cur[i-1] ^ fb);
      end else begin : g_xor
        assign nxt[i] = cur[i-1] ^ fb;
      end
    end else begin : g_plain
      assign nxt[i] = cur[i-1];
    end
  end
endmodule

// File: rtl/prng_state_reg.sv
module prng_state_reg #(
  parameter int              WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [WIDTH-1:0] seed_in,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] state
);
  import prng_pkg::*;

  prng_act_e act;

  // Reset beats load, load beats stepping.
  always_comb begin
    if (rst)          act = ACT_RESET;
    else if (load)    act = ACT_LOAD;
    else if (advance) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    case (act)
      ACT_RESET: state <= RST_VAL;
      ACT_LOAD:  state <= seed_in;
      ACT_STEP:  state <= nxt;
      default:   state <= state;
    endcase
  end
endmodule

// File: rtl/galois_prng.sv
module galois_prng #(
  parameter int WIDTH   = 8,
  parameter bit XNOR_FB = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed_in,
  input  logic             advance,
  output logic             serial_out,
  output logic [WIDTH-1:0] state_out
);
  // Single set bit: away from both lock-up words for any WIDTH >= 2.
  localparam logic [WIDTH-1:0] RST_SEED = WIDTH'(1);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;

  prng_next_state #(.WIDTH(WIDTH), .XNOR_FB(XNOR_FB)) u_next (
    .cur (state_q),
    .nxt (state_nxt)
  );

  prng_state_reg #(.WIDTH(WIDTH), .RST_VAL(RST_SEED)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .advance (advance),
    .seed_in (seed_in),
    .nxt     (state_nxt),
    .state   (state_q)
  );

  assign state_out  = state_q;
  assign serial_out = state_q[WIDTH-1];
endmodule

// File: rtl/prng_checker.sv
module prng_checker #(
  parameter int WIDTH   = 8,
  parameter bit XNOR_FB = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             advance,
  input logic [WIDTH-1:0] seed_in,
  input logic [WIDTH-1:0] state_out
);
  localparam logic [WIDTH-1:0] LOCK = {WIDTH{XNOR_FB}};

  AST_RESET_SEED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_out == WIDTH'(1)); // R1

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> state_out == $past(seed_in)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(state_out)); // R3

  AST_TOP_TO_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (!load && advance) |=> state_out[0] == $past(state_out[WIDTH-1])); // R4

  AST_NO_LOCKUP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!load && state_out != LOCK) |=> state_out != LOCK); // R6

  AST_LOCKUP_STICKS: assert property (@(posedge clk) disable iff (rst)
    (!load && state_out == LOCK) |=> state_out == LOCK); // R7
endmodule

bind galois_prng prng_checker #(.WIDTH(WIDTH), .XNOR_FB(XNOR_FB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .advance   (advance),
  .seed_in   (seed_in),
  .state_out (state_out)
);

// File: tb/galois_prng_tb.sv
`timescale 1ns/1ps
module galois_prng_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference taps from R5.
  function automatic logic [15:0] model_taps(input int w);
    case (w)
      3, 4, 6, 7, 15: return 16'h0003;
      5, 11:          return 16'h0005;
      8:              return 16'h001D;
      9:              return 16'h0011;
      10:             return 16'h0009;
      12:             return 16'h0053;
      13:             return 16'h001B;
      14:             return 16'h0443;
      16:             return 16'h100B;
      default:        return 16'h0000;
    endcase
  endfunction

  // One advance as R4 defines it.
  function automatic logic [15:0] model_step(input int w, input bit xn, input logic [15:0] s);
    logic [15:0] m = model_taps(w);
    logic        top = s[w-1];
    logic [15:0] n = '0;
    n[0] = top;
    for (int i = 1; i < w; i++) begin
      if (m[i]) n[i] = xn ? ~(s[i-1] ^ top) : (s[i-1] ^ top);
      else      n[i] = s[i-1];
    end
    return n;
  endfunction

  // ---------------- directed DUT with scoreboard ----------------
  logic          rst = 1'b1, load = 1'b0, advance = 1'b0;
  logic [DW-1:0] seed_in = '0;
  logic          serial_out;
  logic [DW-1:0] state_out;

  galois_prng #(.WIDTH(DW), .XNOR_FB(1'b0)) u_dut (
    .clk(clk), .rst(rst), .load(load), .seed_in(seed_in),
    .advance(advance), .serial_out(serial_out), .state_out(state_out)
  );

  typedef struct { logic [15:0] exp; string req; } sb_item_t;
  sb_item_t    sb_q[$];
  logic [15:0] model_state = 16'h0001;

  task automatic drive(input bit r, input bit l, input logic [DW-1:0] s, input bit a, input string req);
    sb_item_t it;
    @(negedge clk);
    rst = r; load = l; seed_in = s; advance = a;
    if (r)      model_state = 16'h0001;
    else if (l) model_state = 16'(s);
    else if (a) model_state = model_step(DW, 1'b0, model_state);
    it.exp = model_state;
    it.req = req;
    sb_q.push_back(it);
  endtask

  always begin
    sb_item_t it;
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(16'(state_out) == it.exp, it.req, 16'(state_out), it.exp);
      check(serial_out == it.exp[DW-1], "R8", 16'(serial_out), 16'(it.exp[DW-1]));
    end
  end

  // ---------------- sweep over all lengths and feedback types ----------------
  logic sw_rst = 1'b1, sw_adv = 1'b0;
  logic rst_seen = 1'b1, adv_seen = 1'b0;
  always @(posedge clk) begin
    rst_seen <= sw_rst;
    adv_seen <= sw_adv && !sw_rst;
  end

  logic [27:0] sw_period_ok, sw_match_ok, sw_lock_ok;

  for (genvar f = 0; f < 2; f++) begin : g_fb
    for (genvar w = 3; w <= 16; w++) begin : g_len
      localparam int IDX = f * 14 + (w - 3);
      localparam logic [15:0] LOCKW = (f == 1) ? 16'((32'd1 << w) - 1) : 16'h0000;
      logic         s_serial;
      logic [w-1:0] s_state;
      logic [15:0]  ref_s = 16'h0001;
      int           steps = 0, first_ret = 0, mism = 0;
      bit           lock_hit = 1'b0;

      galois_prng #(.WIDTH(w), .XNOR_FB(f == 1)) u_sweep (
        .clk(clk), .rst(sw_rst), .load(1'b0), .seed_in('0),
        .advance(sw_adv), .serial_out(s_serial), .state_out(s_state)
      );

      always @(negedge clk) begin
        if (rst_seen) begin
          ref_s = 16'h0001; steps = 0; first_ret = 0;
        end else if (adv_seen) begin
          ref_s = model_step(w, f == 1, ref_s);
          steps++;
          if (16'(s_state) != ref_s || s_serial != s_state[w-1]) mism++;
          if (16'(s_state) == LOCKW) lock_hit = 1'b1;
          if (ref_s == 16'h0001 && first_ret == 0) first_ret = steps;
        end
      end

      assign sw_period_ok[IDX] = (first_ret == ((1 << w) - 1));
      assign sw_match_ok[IDX]  = (mism == 0);
      assign sw_lock_ok[IDX]   = !lock_hit;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    drive(1, 1, 8'h5A, 1, "R1");           // reset beats load and advance
    drive(0, 1, 8'hA5, 1, "R2");           // load beats advance
    for (int i = 0; i < 10; i++) drive(0, 0, 8'h00, 1, "R4");
    for (int i = 0; i < 3; i++)  drive(0, 0, 8'hFF, 0, "R3");
    drive(0, 1, 8'h00, 0, "R7");           // lock-up word for XOR
    for (int i = 0; i < 3; i++)  drive(0, 0, 8'h00, 1, "R7");
    drive(0, 1, 8'h80, 0, "R8");           // top bit set: serial high
    drive(0, 0, 8'h00, 1, "R5");           // 0x80 steps to 0x1D
    drive(0, 1, 8'h3C, 1, "R2");
    drive(0, 0, 8'h00, 1, "R4");
    drive(1, 0, 8'h00, 0, "R1");
    drive(0, 0, 8'h00, 0, "R3");
    @(negedge clk);
    @(negedge clk);
    check(sb_q.size() == 0, "R1", 16'(sb_q.size()), 16'd0);

    // Sweep: reset, then advance for one full 16-bit period and a margin.
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk);
    @(negedge clk); sw_rst = 1'b0; sw_adv = 1'b1;
    repeat (65535 + 4) @(negedge clk);
    sw_adv = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 28; k++) begin
      check(sw_period_ok[k], "R6", 16'(k), 16'(k));
      check(sw_match_ok[k],  "R5", 16'(k), 16'(k));
      check(sw_lock_ok[k],   "R6", 16'(k), 16'(k));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule